// File: doc/BRIEF.md
# In-system flash programming sequencer

This block sits on the device side of a JTAG test port and runs in-system programming of a small on-chip configuration flash. The port's instruction logic decodes host instructions into one-cycle command strobes. The block then opens and closes an ISP session, reports a fixed identification code, erases the whole array, programs one word at a time and reads words back so the host can compare them. A full run goes open session, read ID, erase, program every word, verify every word, close session. A verify-only run leaves out the erase and program steps.

Erase and program have no timer of their own. After the command is accepted, the block counts the TCK cycles the TAP spends in Run-Test/Idle. The operation takes effect when the TAP leaves that state, and only if the dwell reached the required count. Both counts are parameters in TCK cycles. One extra control word sits just above the data array and is written with the same bit-clearing rule. One of its bits, when cleared, hides the data array from readback. Another bit, meant to be written last, marks the image as complete and lets the user I/O drive once the session closes. Only a full erase sets either bit back.

Top module: `isp_flash_seq`

## Requirements
- R1: Once reset is applied, isp_mode, busy, pulse_err and rd_valid are 0. The array and the control word are all ones, so secure, isp_done and user_io_en are 0.
- R2: Command codes on cmd_op are 1 open session, 2 read ID, 3 erase, 4 program, 5 verify, 6 close session, 7 set address and 0 no-op. Codes 1 and 6 set and clear isp_mode. Any command that arrives while busy is 1 is dropped.
- R3: Read ID is accepted in or out of a session. One cycle later, rd_valid is 1 and rd_data holds ID_CODE.
- R4: An erase whose Run-Test/Idle dwell reaches ERASE_CYC cycles sets every data word and the control word to all ones. This clears secure and isp_done.
- R5: A program whose dwell reaches PROG_CYC cycles replaces the word at the address pointer with (old word AND cmd_arg latched at the command), then adds one to the pointer. Set address loads the pointer from the low bits of cmd_arg. Address DEPTH selects the control word.
- R6: If the dwell of an erase or program is at least one cycle but less than its count, nothing in the array or the control word changes and pulse_err is set. pulse_err clears when the next erase or program is accepted.
- R7: Verify sets rd_valid one cycle later, with rd_data holding the word at the pointer, zero-extended. It then adds one to the pointer. Addresses above DEPTH read as all ones.
- R8: secure is the inverse of control-word bit 0. While secure is 1, a verify of any data address returns zero. The control word itself still reads back.
- R9: isp_done is the inverse of control-word bit 1. user_io_en is 1 only when isp_done is 1 and isp_mode is 0.
- R10: Outside a session, erase, program, verify and set address are ignored: busy stays 0, rd_valid stays 0 and the array keeps its contents.
- R11: busy rises the cycle after an erase or program is accepted. Dwell is counted only in cycles where tap_idle is 1. The operation finishes on the first cycle with tap_idle at 0 after at least one idle cycle, and busy falls at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock (TCK) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_op | input | 3 | Command code |
| cmd_arg | input | DW | Program data or address for set address |
| tap_idle | input | 1 | TAP controller is in Run-Test/Idle |
| isp_mode | output | 1 | ISP session open |
| busy | output | 1 | Erase or program waiting for its dwell to end |
| pulse_err | output | 1 | Last erase or program had too short a dwell |
| rd_valid | output | 1 | rd_data updated this cycle |
| rd_data | output | IDW | ID code or verify data |
| secure | output | 1 | Readback of the data array blocked |
| isp_done | output | 1 | Image marked complete |
| user_io_en | output | 1 | User I/O may drive |

## Verification
The hardest cases to reach are those where the exact length of the Run-Test/Idle dwell decides the outcome. These are an erase held one cycle short while the security bit is set, and a program armed while the TAP is still away from idle. The stimulus holds tap_idle for exact cycle counts: one below and exactly at each threshold. It also leaves tap_idle low for several cycles after arming, to show that nothing finishes before the first idle cycle. Array contents are then read back through verify at specific addresses, so any write that should not have happened shows up at the ports.

// File: rtl/isp_seq_pkg.sv
package isp_seq_pkg;
  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_ENTER    = 3'd1,
    OP_READ_ID  = 3'd2,
    OP_ERASE    = 3'd3,
    OP_PROGRAM  = 3'd4,
    OP_VERIFY   = 3'd5,
    OP_EXIT     = 3'd6,
    OP_SET_ADDR = 3'd7
  } isp_op_e;
endpackage

// File: rtl/isp_dwell_timer.sv
module isp_dwell_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tap_idle,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] SAT = '1;

  logic [CW-1:0] count_q, count_d;

  always_comb begin
    count_d = count_q;
    if (!run)
      count_d = '0;
    else if (tap_idle && (count_q != SAT))
      count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count = count_q;

  // R11
  dwell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tap_idle) |=> $stable(count_q));

  // R11
  dwell_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count_q == '0));
endmodule

// File: rtl/isp_cfg_array.sv
module isp_cfg_array #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          erase_en,
  input  logic          prog_en,
  input  logic [PW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_word,
  output logic [DW-1:0] ctrl_word
);
  localparam logic [PW-1:0] CTRL_ADDR = PW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] mem_d [DEPTH];
  logic [DW-1:0] ctrl_q, ctrl_d;
  logic          in_data, in_ctrl;

  assign in_data = (addr < CTRL_ADDR);
  assign in_ctrl = (addr == CTRL_ADDR);

  always_comb begin
    mem_d  = mem_q;
    ctrl_d = ctrl_q;
    if (erase_en) begin
      for (int i = 0; i < DEPTH; i++) mem_d[i] = '1;
      ctrl_d = '1;
    end else if (prog_en) begin
      if (in_data)      mem_d[addr[AW-1:0]] = mem_q[addr[AW-1:0]] & wdata;
      else if (in_ctrl) ctrl_d = ctrl_q & wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
      ctrl_q <= '1;
    end else begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
      ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    if (in_data)      rd_word = mem_q[addr[AW-1:0]];
    else if (in_ctrl) rd_word = ctrl_q;
    else              rd_word = '1;
  end

  assign ctrl_word = ctrl_q;

  // R5
  prog_clears_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && !erase_en && in_data) |=>
      ((mem_q[$past(addr[AW-1:0])] & ~$past(wdata)) == '0));

  // R4
  erase_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_en |=> ((mem_q[0] == '1) && (mem_q[DEPTH-1] == '1) && (ctrl_q == '1)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!erase_en && !prog_en) |=> ($stable(ctrl_q) && $stable(mem_q[0])));
endmodule

// File: rtl/isp_flash_seq.sv
module isp_flash_seq
  import isp_seq_pkg::*;
#(
  parameter int          DW        = 8,
  parameter int          DEPTH     = 16,
  parameter int          IDW       = 32,
  parameter logic [31:0] ID_CODE   = 32'h1357_9BDF,
  parameter int          ERASE_CYC = 3_500_000,
  parameter int          PROG_CYC  = 750
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic [2:0]     cmd_op,
  input  logic [DW-1:0]  cmd_arg,
  input  logic           tap_idle,
  output logic           isp_mode,
  output logic           busy,
  output logic           pulse_err,
  output logic           rd_valid,
  output logic [IDW-1:0] rd_data,
  output logic           secure,
  output logic           isp_done,
  output logic           user_io_en
);
  localparam int AW   = $clog2(DEPTH);
  localparam int PW   = AW + 1;
  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ERASE_N   = CW'(ERASE_CYC);
  localparam logic [CW-1:0] PROG_N    = CW'(PROG_CYC);
  localparam logic [PW-1:0] CTRL_ADDR = PW'(DEPTH);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  isp_op_e        op;
  logic           armed_q, armed_d;
  logic           kind_erase_q, kind_erase_d;
  logic [DW-1:0]  wdata_q, wdata_d;
  logic [PW-1:0]  ptr_q, ptr_d;
  logic           isp_q, isp_d;
  logic           err_q, err_d;
  logic           rdv_q, rdv_d;
  logic [IDW-1:0] rdd_q, rdd_d;

  logic [CW-1:0]  dwell;
  logic [CW-1:0]  need;
  logic           accept, gated, finish, pass;
  logic           erase_en, prog_en;
  logic [DW-1:0]  rd_word, ctrl_word;
  logic           secure_w;

  assign op       = isp_op_e'(cmd_op);
  assign accept   = cmd_valid && !armed_q;
  assign gated    = accept && isp_q;
  assign need     = kind_erase_q ? ERASE_N : PROG_N;
  assign finish   = armed_q && !tap_idle && (dwell != '0);
  assign pass     = (dwell >= need);
  assign erase_en = finish && pass && kind_erase_q;
  assign prog_en  = finish && pass && !kind_erase_q;
  assign secure_w = ~ctrl_word[0];

  isp_dwell_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (armed_q),
    .tap_idle (tap_idle),
    .count    (dwell)
  );

  isp_cfg_array #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .PW(PW)) u_array (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .erase_en  (erase_en),
    .prog_en   (prog_en),
    .addr      (ptr_q),
    .wdata     (wdata_q),
    .rd_word   (rd_word),
    .ctrl_word (ctrl_word)
  );

  always_comb begin
    armed_d      = armed_q;
    kind_erase_d = kind_erase_q;
    wdata_d      = wdata_q;
    ptr_d        = ptr_q;
    isp_d        = isp_q;
    err_d        = err_q;
    rdv_d        = 1'b0;
    rdd_d        = rdd_q;

    if (finish) begin
      armed_d = 1'b0;
      if (!pass)              err_d = 1'b1;
      else if (!kind_erase_q) ptr_d = ptr_q + 1'b1;
    end

    if (accept) begin
      unique case (op)
        OP_ENTER:   isp_d = 1'b1;
        OP_EXIT:    isp_d = 1'b0;
        OP_READ_ID: begin
          rdv_d = 1'b1;
          rdd_d = IDW'(ID_CODE);
        end
        OP_SET_ADDR: if (gated) ptr_d = cmd_arg[PW-1:0];
        OP_VERIFY: if (gated) begin
          rdv_d = 1'b1;
          rdd_d = (secure_w && (ptr_q < CTRL_ADDR)) ? '0
                                                    : {{(IDW-DW){1'b0}}, rd_word};
          ptr_d = ptr_q + 1'b1;
        end
        OP_ERASE, OP_PROGRAM: if (gated) begin
          armed_d      = 1'b1;
          kind_erase_d = (op == OP_ERASE);
          wdata_d      = cmd_arg;
          err_d        = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      armed_q      <= 1'b0;
      kind_erase_q <= 1'b0;
      wdata_q      <= '0;
      ptr_q        <= '0;
      isp_q        <= 1'b0;
      err_q        <= 1'b0;
      rdv_q        <= 1'b0;
      rdd_q        <= '0;
    end else begin
      armed_q      <= armed_d;
      kind_erase_q <= kind_erase_d;
      wdata_q      <= wdata_d;
      ptr_q        <= ptr_d;
      isp_q        <= isp_d;
      err_q        <= err_d;
      rdv_q        <= rdv_d;
      rdd_q        <= rdd_d;
    end
  end

  assign isp_mode   = isp_q;
  assign busy       = armed_q;
  assign pulse_err  = err_q;
  assign rd_valid   = rdv_q;
  assign rd_data    = rdd_q;
  assign secure     = secure_w;
  assign isp_done   = ~ctrl_word[1];
  assign user_io_en = ~ctrl_word[1] && !isp_q;

  // R10
  outside_isp_ignore_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_valid && !busy && !isp_mode &&
     ((cmd_op == OP_ERASE) || (cmd_op == OP_PROGRAM))) |=> !busy);

  // R8
  secure_readback_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_valid && !busy && isp_mode && (cmd_op == OP_VERIFY) && secure &&
     (ptr_q < CTRL_ADDR)) |=> (rd_valid && (rd_data == '0)));

  // R2
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && cmd_valid && (cmd_op == OP_VERIFY)) |=> !rd_valid);

  // R6
  short_pulse_err_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && !tap_idle && (dwell != '0) && (dwell < need)) |=> (pulse_err && !busy));
endmodule

// File: tb/isp_flash_seq_bench.sv
`timescale 1ns/1ps
module isp_flash_seq_bench;
  import isp_seq_pkg::*;

  localparam int          EC  = 35;
  localparam int          PC  = 7;
  localparam logic [31:0] IDV = 32'h2468_ACE1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [7:0]  cmd_arg;
  logic        tap_idle;
  logic        isp_mode, busy, pulse_err, rd_valid, secure, isp_done, user_io_en;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  isp_flash_seq #(
    .DW(8), .DEPTH(16), .IDW(32), .ID_CODE(IDV), .ERASE_CYC(EC), .PROG_CYC(PC)
  ) u_isp_flash_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .tap_idle(tap_idle), .isp_mode(isp_mode), .busy(busy),
    .pulse_err(pulse_err), .rd_valid(rd_valid), .rd_data(rd_data),
    .secure(secure), .isp_done(isp_done), .user_io_en(user_io_en)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  arg;
    logic [7:0]  dwell;
    logic        exp_err;
    logic        chk_rd;
    logic [31:0] exp_rd;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{OP_ENTER,    8'h00, 8'd0,    1'b0, 1'b0, 32'h0},
    '{OP_READ_ID,  8'h00, 8'd0,    1'b0, 1'b1, IDV},
    '{OP_ERASE,    8'h00, 8'(EC),  1'b0, 1'b0, 32'h0},
    '{OP_SET_ADDR, 8'h00, 8'd0,    1'b0, 1'b0, 32'h0},
    '{OP_PROGRAM,  8'hA5, 8'(PC),  1'b0, 1'b0, 32'h0},
    '{OP_PROGRAM,  8'h3C, 8'(PC),  1'b0, 1'b0, 32'h0},
    '{OP_PROGRAM,  8'h00, 8'(PC-1),1'b1, 1'b0, 32'h0},
    '{OP_PROGRAM,  8'h0F, 8'(PC),  1'b0, 1'b0, 32'h0},
    '{OP_SET_ADDR, 8'h00, 8'd0,    1'b0, 1'b0, 32'h0},
    '{OP_VERIFY,   8'h00, 8'd0,    1'b0, 1'b1, 32'h0000_00A5},
    '{OP_VERIFY,   8'h00, 8'd0,    1'b0, 1'b1, 32'h0000_003C},
    '{OP_VERIFY,   8'h00, 8'd0,    1'b0, 1'b1, 32'h0000_000F},
    '{OP_SET_ADDR, 8'h00, 8'd0,    1'b0, 1'b0, 32'h0},
    '{OP_PROGRAM,  8'hF0, 8'(PC),  1'b0, 1'b0, 32'h0},
    '{OP_SET_ADDR, 8'h00, 8'd0,    1'b0, 1'b0, 32'h0},
    '{OP_VERIFY,   8'h00, 8'd0,    1'b0, 1'b1, 32'h0000_00A0},
    '{OP_EXIT,     8'h00, 8'd0,    1'b0, 1'b0, 32'h0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] arg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = OP_NOP; cmd_arg = 8'h00;
  endtask

  task automatic do_dwell(input int k);
    tap_idle = 1'b1;
    repeat (k) @(negedge clk);
    tap_idle = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic verify_at(input logic [7:0] a, input logic [31:0] exp, input string req);
    issue(OP_SET_ADDR, a);
    issue(OP_VERIFY, 8'h00);
    chk(rd_valid && (rd_data == exp), req, rd_data, exp);
  endtask

  task automatic check_reset_state(input string req);
    chk(!isp_mode && !busy && !pulse_err && !rd_valid, req,
        {28'h0, isp_mode, busy, pulse_err, rd_valid}, 32'h0);
    chk(!secure && !isp_done && !user_io_en, req,
        {29'h0, secure, isp_done, user_io_en}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = OP_NOP; cmd_arg = 8'h00; tap_idle = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_state("R1");

    // Table walk: a full programming run
    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].op, VECS[i].arg);
      if (VECS[i].chk_rd)
        chk(rd_valid && (rd_data == VECS[i].exp_rd),
            (VECS[i].op == OP_READ_ID) ? "R3" : "R7 R5", rd_data, VECS[i].exp_rd);
      if (VECS[i].dwell != 0) begin
        do_dwell(int'(VECS[i].dwell));
        chk((pulse_err == VECS[i].exp_err) && !busy,
            VECS[i].exp_err ? "R6" : ((VECS[i].op == OP_ERASE) ? "R4" : "R5"),
            {30'h0, busy, pulse_err}, {31'h0, VECS[i].exp_err});
      end
    end
    chk(!isp_mode, "R2", {31'h0, isp_mode}, 32'h0);

    // R3 outside a session, R10 gating
    issue(OP_READ_ID, 8'h00);
    chk(rd_valid && (rd_data == IDV), "R3", rd_data, IDV);
    issue(OP_SET_ADDR, 8'h00);
    issue(OP_PROGRAM, 8'h00);
    chk(!busy, "R10", {31'h0, busy}, 32'h0);
    do_dwell(PC);
    issue(OP_VERIFY, 8'h00);
    chk(!rd_valid, "R10", {31'h0, rd_valid}, 32'h0);
    issue(OP_ENTER, 8'h00);
    chk(isp_mode, "R2", {31'h0, isp_mode}, 32'h1);
    verify_at(8'h00, 32'h0000_00A0, "R10");

    // R11 arming without idle, R2 drop while busy
    issue(OP_SET_ADDR, 8'h03);
    issue(OP_PROGRAM, 8'h00);
    chk(busy, "R11", {31'h0, busy}, 32'h1);
    issue(OP_VERIFY, 8'h00);
    chk(!rd_valid, "R2", {31'h0, rd_valid}, 32'h0);
    repeat (3) @(negedge clk);
    chk(busy, "R11", {31'h0, busy}, 32'h1);
    do_dwell(PC);
    chk(!busy && !pulse_err, "R11", {30'h0, busy, pulse_err}, 32'h0);
    verify_at(8'h03, 32'h0000_0000, "R5");

    // R9 image-complete bit
    issue(OP_SET_ADDR, 8'h10);
    issue(OP_PROGRAM, 8'hFD);
    do_dwell(PC);
    chk(isp_done && !user_io_en, "R9", {30'h0, isp_done, user_io_en}, 32'h2);
    issue(OP_EXIT, 8'h00);
    chk(user_io_en, "R9", {31'h0, user_io_en}, 32'h1);
    issue(OP_ENTER, 8'h00);
    chk(!user_io_en, "R9", {31'h0, user_io_en}, 32'h0);

    // R8 security bit
    issue(OP_SET_ADDR, 8'h10);
    issue(OP_PROGRAM, 8'hFE);
    do_dwell(PC);
    chk(secure, "R8", {31'h0, secure}, 32'h1);
    verify_at(8'h00, 32'h0000_0000, "R8");
    verify_at(8'h10, 32'h0000_00FC, "R8");

    // R6 short erase leaves security set, R4 full erase clears it
    issue(OP_ERASE, 8'h00);
    do_dwell(EC - 1);
    chk(pulse_err && secure, "R6", {30'h0, pulse_err, secure}, 32'h3);
    verify_at(8'h10, 32'h0000_00FC, "R6");
    issue(OP_ERASE, 8'h00);
    do_dwell(EC);
    chk(!pulse_err && !secure && !isp_done, "R4",
        {29'h0, pulse_err, secure, isp_done}, 32'h0);
    verify_at(8'h00, 32'h0000_00FF, "R4");
    verify_at(8'h03, 32'h0000_00FF, "R4");
    verify_at(8'h14, 32'h0000_00FF, "R7");

    // R1 reset during an armed program
    issue(OP_SET_ADDR, 8'h01);
    issue(OP_PROGRAM, 8'h00);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_state("R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule